// File: doc/BRIEF.md
# Low-Power Entry and Wakeup Controller

This block decides when a processor core may drop into a low-power state and when it must come back. The core signals its intent with single-cycle strobes: wait-for-interrupt, wait-for-event, or an exception return while a sleep-on-exit flag is set. The controller refuses the request when a wake reason is already present. Otherwise it records how sleep was entered, because that choice fixes which conditions end the sleep. A light sleep ends with a one-cycle wake pulse, and also with a take-interrupt pulse when the wake reason is an interrupt the core has to service. When a deep mode is selected at entry, the block ends up in a state that only a reset pin request, a watchdog reset or a rising edge on an enabled wakeup pin can leave. Each of these raises a full-reset request, not a resume.

The block also sequences the exit from low-power run mode. It drops the regulator low-power request, waits until the regulator status flag has read low for a configured number of consecutive cycles, and only then allows the system clock to be raised again. An internal event latch remembers an event that arrived while the core was running, so a later wait-for-event returns at once.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After reset, `lp_state` is 0 (running), `wake_pulse`, `take_irq`, `full_rst_req` and `lpr_req` are 0, `clk_raise_ok` is 1, and the event latch is clear, so the first `wfe_req` puts the block to sleep.
- R2: While running, `wfi_req` moves `lp_state` to 1 (interrupt sleep), `wfe_req` moves it to 2 (event sleep), and `exc_ret` with `sleep_on_exit` high moves it to 1. An `exc_ret` with `sleep_on_exit` low has no effect. Each change is visible one clock edge after the strobe.
- R3: A line is accepted when its bits in `irq_pend`, `irq_en` and `irq_prio_ok` are all 1. If any line is accepted, `wfi_req` and a sleep-on-exit return are ignored and `lp_state` stays 0.
- R4: In state 1, an accepted line returns `lp_state` to 0 and pulses `wake_pulse` and `take_irq` high together for exactly one cycle. A pending line that is disabled, or whose priority is not sufficient, does not wake.
- R5: In state 2 with `sev_on_pend` low, only an accepted line wakes the core, with `take_irq`. A disabled line that newly becomes pending does not wake.
- R6: In state 2 with `sev_on_pend` high, any `irq_pend` bit that rises from 0 to 1 wakes the core, even when the line is disabled. `take_irq` is high only if some line is accepted.
- R7: `evt_in` wakes a state-2 sleep with `wake_pulse` high and `take_irq` low. It does not wake a state-1 sleep.
- R8: The event latch is set while running by `evt_in`, or by a newly pending line when `sev_on_pend` is high. A `wfe_req` with the latch set clears it and leaves `lp_state` at 0. The next `wfe_req` sleeps.
- R9: With `deep_sel` high, an accepted sleep request moves `lp_state` to 3. Interrupts and events do not exit state 3. `ext_rst_req`, `wdg_rst` or an enabled wakeup-pin rise does exit it: `full_rst_req` goes high for one cycle, `lp_state` returns to 0, and `wake_pulse` stays low.
- R10: Each `wkp_pin` passes through a two-flop synchronizer. A 0-to-1 change on a pin whose `wkp_en` bit is 1 raises `full_rst_req` on the third clock edge after the change. A pin whose enable bit is 0 is ignored.
- R11: `lprun_enter` sets `lpr_req` to 1 and `clk_raise_ok` to 0. With `lpr_req` set, `lprun_leave` clears `lpr_req` and moves `lp_state` to 4. The block returns to 0 with `clk_raise_ok` at 1 on the edge that completes SETTLE_CYC consecutive edges with `reg_lp_flag` sampled low. A high sample restarts the count.
- R12: Sleep and low-power-run strobes are ignored in every state other than 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt strobe |
| wfe_req | input | 1 | Wait-for-event strobe |
| exc_ret | input | 1 | Exception-return strobe |
| sleep_on_exit | input | 1 | Sleep on exception return |
| sev_on_pend | input | 1 | Newly pending lines count as events |
| irq_pend | input | N_IRQ | Per-line pending |
| irq_en | input | N_IRQ | Per-line enable |
| irq_prio_ok | input | N_IRQ | Per-line priority sufficient |
| evt_in | input | 1 | External event line |
| deep_sel | input | 1 | Enter the deep mode on sleep |
| ext_rst_req | input | 1 | Reset pin request, active high |
| wdg_rst | input | 1 | Watchdog reset |
| wkp_pin | input | N_WKP | Asynchronous wakeup pins |
| wkp_en | input | N_WKP | Wakeup pin enables |
| lprun_enter | input | 1 | Enter low-power run |
| lprun_leave | input | 1 | Leave low-power run |
| reg_lp_flag | input | 1 | Regulator still in low-power |
| lp_state | output | 3 | 0 run, 1 interrupt sleep, 2 event sleep, 3 deep, 4 run-exit |
| wake_pulse | output | 1 | One-cycle resume pulse |
| take_irq | output | 1 | Resume must service an interrupt |
| full_rst_req | output | 1 | One-cycle full reset request |
| lpr_req | output | 1 | Regulator low-power request |
| clk_raise_ok | output | 1 | System clock may be raised |

## Verification
The bench builds the block with four interrupt lines, two wakeup pins and a settle count of three. Four lines allow separate stimuli for an accepted line, a disabled line and a line whose priority is too low. With two pins, an enabled pin and a disabled pin can change at the same time. A settle count of three leaves room to break a run of low regulator samples partway through and to see the count start over before the clock-raise permission returns.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_SLP_WFI  = 3'd1,
        ST_SLP_WFE  = 3'd2,
        ST_DEEP     = 3'd3,
        ST_LPR_EXIT = 3'd4
    } lpw_state_e;

    typedef struct packed {
        lpw_state_e st;
        logic       evt_latch;
        logic       wake;
        logic       take;
        logic       frst;
        logic       lpr;
        logic       raise_ok;
    } lpw_regs_t;

endpackage

// File: rtl/lpw_irq_eval.sv
module lpw_irq_eval #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] pend_i,
    input  logic [N_IRQ-1:0] en_i,
    input  logic [N_IRQ-1:0] prio_i,
    output logic             acc_any_o,
    output logic             new_any_o
);
    logic [N_IRQ-1:0] pend_d, pend_q;
    logic [N_IRQ-1:0] acc_vec, new_vec;

    always_comb begin
        pend_d  = pend_i;
        acc_vec = pend_i & en_i & prio_i;
        new_vec = pend_i & ~pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign acc_any_o = |acc_vec;
    assign new_any_o = |new_vec;
endmodule

// File: rtl/lpw_wkp_sync.sv
module lpw_wkp_sync #(
    parameter int N_WKP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_WKP-1:0] pin_i,
    input  logic [N_WKP-1:0] en_i,
    output logic             rise_any_o
);
    logic [N_WKP-1:0] s1_q, s2_q, s3_q;
    logic [N_WKP-1:0] s1_d, s2_d, s3_d;
    logic [N_WKP-1:0] rise_vec;

    always_comb begin
        s1_d = pin_i;
        s2_d = s1_q;
        s3_d = s2_q;
    end

    for (genvar g = 0; g < N_WKP; g++) begin : g_pin
        assign rise_vec[g] = s2_q[g] & ~s3_q[g] & en_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign rise_any_o = |rise_vec;
endmodule

// File: rtl/lpw_reg_seq.sv
module lpw_reg_seq #(
    parameter int SETTLE_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic flag_i,
    output logic done_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!active_i || flag_i) cnt_d = '0;
        else if (cnt_q == LAST)  cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = active_i & ~flag_i & (cnt_q == LAST);
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int N_IRQ      = 8,
    parameter int N_WKP      = 4,
    parameter int SETTLE_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_req,
    input  logic             wfe_req,
    input  logic             exc_ret,
    input  logic             sleep_on_exit,
    input  logic             sev_on_pend,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_prio_ok,
    input  logic             evt_in,
    input  logic             deep_sel,
    input  logic             ext_rst_req,
    input  logic             wdg_rst,
    input  logic [N_WKP-1:0] wkp_pin,
    input  logic [N_WKP-1:0] wkp_en,
    input  logic             lprun_enter,
    input  logic             lprun_leave,
    input  logic             reg_lp_flag,
    output logic [2:0]       lp_state,
    output logic             wake_pulse,
    output logic             take_irq,
    output logic             full_rst_req,
    output logic             lpr_req,
    output logic             clk_raise_ok
);
    lpw_regs_t r_d, r_q;
    logic acc_any, new_any, wkp_rise, reg_done;
    logic evt_set, deep_exit;

    lpw_irq_eval #(.N_IRQ(N_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .pend_i(irq_pend), .en_i(irq_en), .prio_i(irq_prio_ok),
        .acc_any_o(acc_any), .new_any_o(new_any)
    );

    lpw_wkp_sync #(.N_WKP(N_WKP)) u_wkp (
        .clk(clk), .rst_n(rst_n),
        .pin_i(wkp_pin), .en_i(wkp_en),
        .rise_any_o(wkp_rise)
    );

    lpw_reg_seq #(.SETTLE_CYC(SETTLE_CYC)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .active_i(r_q.st == ST_LPR_EXIT), .flag_i(reg_lp_flag),
        .done_o(reg_done)
    );

    always_comb begin
        evt_set   = evt_in | (sev_on_pend & new_any);
        deep_exit = ext_rst_req | wdg_rst | wkp_rise;
        r_d       = r_q;
        r_d.wake  = 1'b0;
        r_d.take  = 1'b0;
        r_d.frst  = 1'b0;
        unique case (r_q.st)
            ST_RUN: begin
                if (evt_set) r_d.evt_latch = 1'b1;
                if (lprun_enter) begin
                    r_d.lpr      = 1'b1;
                    r_d.raise_ok = 1'b0;
                end
                if (lprun_leave && r_q.lpr) begin
                    r_d.lpr = 1'b0;
                    r_d.st  = ST_LPR_EXIT;
                end else if (wfi_req) begin
                    if (!acc_any) r_d.st = deep_sel ? ST_DEEP : ST_SLP_WFI;
                end else if (wfe_req) begin
                    if (r_q.evt_latch) r_d.evt_latch = 1'b0;
                    else               r_d.st = deep_sel ? ST_DEEP : ST_SLP_WFE;
                end else if (exc_ret && sleep_on_exit && !acc_any) begin
                    r_d.st = deep_sel ? ST_DEEP : ST_SLP_WFI;
                end
            end
            ST_SLP_WFI: begin
                if (acc_any) begin
                    r_d.st   = ST_RUN;
                    r_d.wake = 1'b1;
                    r_d.take = 1'b1;
                end
            end
            ST_SLP_WFE: begin
                if (acc_any) begin
                    r_d.st   = ST_RUN;
                    r_d.wake = 1'b1;
                    r_d.take = 1'b1;
                end else if (evt_set) begin
                    r_d.st   = ST_RUN;
                    r_d.wake = 1'b1;
                end
            end
            ST_DEEP: begin
                if (deep_exit) begin
                    r_d.st        = ST_RUN;
                    r_d.frst      = 1'b1;
                    r_d.evt_latch = 1'b0;
                    r_d.lpr       = 1'b0;
                    r_d.raise_ok  = 1'b1;
                end
            end
            ST_LPR_EXIT: begin
                if (reg_done) begin
                    r_d.st       = ST_RUN;
                    r_d.raise_ok = 1'b1;
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_RUN;
            r_q.raise_ok <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign lp_state     = r_q.st;
    assign wake_pulse   = r_q.wake;
    assign take_irq     = r_q.take;
    assign full_rst_req = r_q.frst;
    assign lpr_req      = r_q.lpr;
    assign clk_raise_ok = r_q.raise_ok;
endmodule

// File: rtl/lpw_chk.sv
module lpw_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] lp_state,
    input logic       wake_pulse,
    input logic       take_irq,
    input logic       full_rst_req,
    input logic       lpr_req,
    input logic       clk_raise_ok,
    input logic       reg_lp_flag
);
    p_take_has_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> wake_pulse);

    p_wake_from_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (($past(lp_state) == 3'd1) || ($past(lp_state) == 3'd2)) && (lp_state == 3'd0));

    p_reset_from_deep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full_rst_req |-> ($past(lp_state) == 3'd3) && (lp_state == 3'd0));

    p_one_exit_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wake_pulse, full_rst_req}));

    p_raise_after_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lp_state) == 3'd4) && (lp_state == 3'd0)) |-> clk_raise_ok && !$past(reg_lp_flag));

    p_exit_holds_clock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state == 3'd4) |-> !lpr_req && !clk_raise_ok);
endmodule

bind lp_wake_ctrl lpw_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lp_state(lp_state),
    .wake_pulse(wake_pulse), .take_irq(take_irq), .full_rst_req(full_rst_req),
    .lpr_req(lpr_req), .clk_raise_ok(clk_raise_ok), .reg_lp_flag(reg_lp_flag)
);

// File: tb/tb_lp_wake_ctrl.sv
module tb_lp_wake_ctrl;
    localparam int NI = 4;
    localparam int NW = 2;
    localparam int ST = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_req = 0, wfe_req = 0, exc_ret = 0, sleep_on_exit = 0, sev_on_pend = 0;
    logic [NI-1:0] irq_pend = '0, irq_en = '0, irq_prio_ok = '0;
    logic evt_in = 0, deep_sel = 0, ext_rst_req = 0, wdg_rst = 0;
    logic [NW-1:0] wkp_pin = '0, wkp_en = '0;
    logic lprun_enter = 0, lprun_leave = 0, reg_lp_flag = 1;
    logic [2:0] lp_state;
    logic wake_pulse, take_irq, full_rst_req, lpr_req, clk_raise_ok;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    lp_wake_ctrl #(.N_IRQ(NI), .N_WKP(NW), .SETTLE_CYC(ST)) dut (
        .clk(clk), .rst_n(rst_n),
        .wfi_req(wfi_req), .wfe_req(wfe_req), .exc_ret(exc_ret),
        .sleep_on_exit(sleep_on_exit), .sev_on_pend(sev_on_pend),
        .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio_ok(irq_prio_ok),
        .evt_in(evt_in), .deep_sel(deep_sel), .ext_rst_req(ext_rst_req),
        .wdg_rst(wdg_rst), .wkp_pin(wkp_pin), .wkp_en(wkp_en),
        .lprun_enter(lprun_enter), .lprun_leave(lprun_leave),
        .reg_lp_flag(reg_lp_flag), .lp_state(lp_state),
        .wake_pulse(wake_pulse), .take_irq(take_irq),
        .full_rst_req(full_rst_req), .lpr_req(lpr_req),
        .clk_raise_ok(clk_raise_ok)
    );

    // {entry(0 wfi,1 wfe,2 return), sev, pend, en, prio, evt, exp_wake, exp_take}
    localparam logic [17:0] VEC [11] = '{
        18'b00_0_0001_0001_0001_0_1_1,
        18'b00_0_0010_0000_0010_0_0_0,
        18'b00_0_0100_0100_0000_0_0_0,
        18'b00_0_0000_0000_0000_1_0_0,
        18'b10_0_1000_1000_1000_0_1_1,
        18'b01_0_0001_0001_0001_0_1_1,
        18'b01_0_0010_0000_0000_0_0_0,
        18'b01_1_0010_0000_0000_0_1_0,
        18'b01_1_0100_0100_0100_0_1_1,
        18'b01_0_0000_0000_0000_1_1_0,
        18'b01_1_0000_0000_0000_0_0_0
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_irq();
        sev_on_pend = 0; irq_pend = '0; irq_en = '0; irq_prio_ok = '0; evt_in = 0;
    endtask

    task automatic wake_by_irq();
        irq_pend = 4'b0001; irq_en = 4'b0001; irq_prio_ok = 4'b0001;
        tick();
        clear_irq();
        tick();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 state", lp_state, 0);
        check("R1 wake", wake_pulse, 0);
        check("R1 rst", full_rst_req, 0);
        check("R1 lpr", lpr_req, 0);
        check("R1 raise", clk_raise_ok, 1);

        // table walk: entry and wake sets
        for (int i = 0; i < 11; i++) begin
            logic [1:0] ent;
            logic sv, ev, xw, xt;
            logic [3:0] wp, we, wpr;
            string tg;
            {ent, sv, wp, we, wpr, ev, xw, xt} = VEC[i];
            if (ev) tg = "R7";
            else if (ent == 2'd0 || ent == 2'd2) tg = "R4";
            else if (sv) tg = "R6";
            else tg = "R5";
            case (ent)
                2'd0: wfi_req = 1;
                2'd1: wfe_req = 1;
                default: begin exc_ret = 1; sleep_on_exit = 1; end
            endcase
            tick();
            wfi_req = 0; wfe_req = 0; exc_ret = 0; sleep_on_exit = 0;
            check("R2 entry", lp_state, (ent == 2'd1) ? 2 : 1);
            sev_on_pend = sv; irq_pend = wp; irq_en = we; irq_prio_ok = wpr; evt_in = ev;
            tick();
            check({tg, " wake"}, wake_pulse, xw);
            check({tg, " take"}, take_irq, xt);
            check({tg, " state"}, lp_state, xw ? 0 : ((ent == 2'd1) ? 2 : 1));
            clear_irq();
            tick();
            check("R4 pulse width", wake_pulse, 0);
            if (lp_state != 3'd0) wake_by_irq();
            check("R2 back to run", lp_state, 0);
        end

        // R2 return without sleep-on-exit
        exc_ret = 1; tick(); exc_ret = 0;
        check("R2 plain return", lp_state, 0);

        // R3 wfi blocked by accepted line
        irq_pend = 4'b0010; irq_en = 4'b0010; irq_prio_ok = 4'b0010;
        wfi_req = 1; tick(); wfi_req = 0;
        check("R3 blocked", lp_state, 0);
        clear_irq(); tick();

        // R12 strobes ignored while asleep
        wfi_req = 1; tick(); wfi_req = 0;
        lprun_enter = 1; tick(); lprun_enter = 0;
        check("R12 lpr in sleep", lpr_req, 0);
        wfe_req = 1; tick(); wfe_req = 0;
        check("R12 state", lp_state, 1);
        wake_by_irq();

        // R8 event latch by evt_in
        evt_in = 1; tick(); evt_in = 0;
        wfe_req = 1; tick(); wfe_req = 0;
        check("R8 latch skip", lp_state, 0);
        wfe_req = 1; tick(); wfe_req = 0;
        check("R8 second sleeps", lp_state, 2);
        evt_in = 1; tick(); evt_in = 0;
        check("R8 woke", lp_state, 0);
        tick();
        // R8 latch by newly pending with sev
        sev_on_pend = 1; irq_pend = 4'b0100; tick();
        clear_irq(); tick();
        wfe_req = 1; tick(); wfe_req = 0;
        check("R8 sev latch", lp_state, 0);

        // R9 deep mode
        deep_sel = 1;
        wfi_req = 1; tick(); wfi_req = 0;
        check("R9 deep entry", lp_state, 3);
        irq_pend = 4'b0001; irq_en = 4'b0001; irq_prio_ok = 4'b0001; evt_in = 1;
        tick();
        check("R9 irq no exit", lp_state, 3);
        check("R9 no rst", full_rst_req, 0);
        clear_irq(); tick();
        wdg_rst = 1; tick(); wdg_rst = 0;
        check("R9 wdg rst", full_rst_req, 1);
        check("R9 wdg state", lp_state, 0);
        check("R9 no wake", wake_pulse, 0);
        tick();
        check("R9 rst pulse", full_rst_req, 0);
        wfe_req = 1; tick(); wfe_req = 0;
        check("R9 deep via wfe", lp_state, 3);
        ext_rst_req = 1; tick(); ext_rst_req = 0;
        check("R9 pin rst", full_rst_req, 1);
        tick();

        // R10 wakeup pins
        wkp_en = 2'b10;
        wfi_req = 1; tick(); wfi_req = 0;
        wkp_pin = 2'b01;
        tick(); tick(); tick(); tick();
        check("R10 disabled pin", lp_state, 3);
        wkp_pin = 2'b11;
        tick(); tick();
        check("R10 sync delay", full_rst_req, 0);
        tick();
        check("R10 enabled pin", full_rst_req, 1);
        wkp_pin = '0; deep_sel = 0;
        tick(); tick(); tick();

        // R11 low-power run exit
        lprun_enter = 1; tick(); lprun_enter = 0;
        check("R11 lpr set", lpr_req, 1);
        check("R11 raise low", clk_raise_ok, 0);
        lprun_leave = 1; tick(); lprun_leave = 0;
        check("R11 exit state", lp_state, 4);
        check("R11 lpr clear", lpr_req, 0);
        wfi_req = 1; tick(); wfi_req = 0;
        check("R12 exit ignores wfi", lp_state, 4);
        reg_lp_flag = 0; tick(); tick();
        reg_lp_flag = 1; tick();
        check("R11 restart", lp_state, 4);
        reg_lp_flag = 0; tick(); tick();
        check("R11 not yet", clk_raise_ok, 0);
        tick();
        check("R11 done state", lp_state, 0);
        check("R11 raise ok", clk_raise_ok, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule